// File: doc/BRIEF.md
# Pad Connectivity Self-Test Controller

This block runs a connectivity check on four input pads of a sensor and gives the system direct control of four output pads. Software first sets an arming bit in an engine control register. Any later write to the status address then starts an input test. The block drives a weak pull-up on the pads and samples them. It then drives a weak pull-down and samples them again. It classifies each pad from the two samples and stores the four 2-bit results in one status byte. A pad that follows the pull both times is reported as high-impedance. A pad that holds steady is reported as low or high. A pad that moves against the pull is reported as unknown. The full settle interval is a parameter derived from the clock frequency and a time in microseconds, and it is split evenly between the two pull phases.

An output-test mode is entered by setting one bit in a pad function register. From then on, a test-output register drives the interrupt, general-purpose, MOSI and MISO pads, and a flag tells the serial engine to stay off. Only the synchronous hardware reset clears this mode.

Top module: `pad_selftest_ctrl`

## Requirements
- R1: After reset, every register reads as 0x00 and `busy`, `ovr_en`, `serial_dis`, `pull_up_en`, `pull_dn_en` and `ovr_drive` are all 0.
- R2: A write to address 0x31 starts a test, whatever data it carries, but only when bit 1 of the engine register at 0x61 is 1. `busy` is high in the cycle after the accepted write. While bit 1 is 0, such a write leaves `busy` at 0 and leaves the status byte unchanged.
- R3: The status byte keeps its old value until SETTLE clock cycles after the clock edge that accepted the start write. SETTLE is (CLK_HZ/1e6)*SETTLE_US. The new value appears at that edge, and `busy` falls at the same edge.
- R4: For the first SETTLE/2 cycles of a test, `pull_up_en` is 1 and `pull_dn_en` is 0. For the second SETTLE/2 cycles, `pull_dn_en` is 1 and `pull_up_en` is 0. The two are never high together.
- R5: The status byte at 0x31 holds the result for `pad_in[3]` (reset pad) in bits 7:6, `pad_in[2]` (shutdown pad) in bits 5:4, `pad_in[1]` (general-purpose pad) in bits 3:2 and `pad_in[0]` (interface-select pad) in bits 1:0.
- R6: Each pad is classified from its sample at the end of the pull-up phase and its sample at the end of the pull-down phase. The codes are: 0,0 gives 1 (low); 1,1 gives 2 (high); 1,0 gives 3 (high-impedance); 0,1 gives 0 (unknown).
- R7: A start write that arrives while `busy` is 1 is ignored. The running test finishes at its original time and no second test follows.
- R8: Before output-test mode, `ovr_en`, `serial_dis` and `ovr_drive` are 0. Writing 0x34 with bit 4 set makes `ovr_en` and `serial_dis` 1 in the next cycle. From then on, `ovr_drive` equals bits 3:0 of register 0x33, with bit 3 for the interrupt pad, bit 2 for the general-purpose pad, bit 1 for MOSI and bit 0 for MISO.
- R9: Once entered, output-test mode stays on through any register write, including a write of 0x34 with bit 4 clear. Only `rst` clears it. Bit 4 of the 0x34 readback shows the mode.
- R10: `reg_rdata` returns the addressed register combinationally: 0x61 engine byte, 0x33 test-output byte, 0x34 pad function byte with bit 4 replaced by the mode, and 0x31 status. Any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pad_in | input | 4 | Sampled input pads: 3 reset, 2 shutdown, 1 general-purpose, 0 interface-select |
| pull_up_en | output | 1 | Weak pull-up request to the input pads |
| pull_dn_en | output | 1 | Weak pull-down request to the input pads |
| busy | output | 1 | Input test in progress |
| ovr_en | output | 1 | Output-test mode active, pads take `ovr_drive` |
| ovr_drive | output | 4 | Override values: 3 interrupt, 2 general-purpose, 1 MOSI, 0 MISO |
| serial_dis | output | 1 | Keeps the serial engine disabled |

## Verification
A phase counter that is off by one moves the update of the status byte by a cycle. It also moves the swap from pull-up to pull-down. The bench samples both one cycle before and exactly at the predicted edge, so such a fault shows in the first test. A wrong classification or field placement gives a wrong status byte as soon as the sweep reaches the affected behaviour and pad. The sweep covers all 256 combinations of four pad behaviours. A mode flag that can be cleared shows at `ovr_en` one cycle after the write that clears it.

// File: rtl/pad_selftest_pkg.sv
package pad_selftest_pkg;

    localparam int NPADS = 4;
    localparam int NOUT  = 4;

    localparam logic [7:0] ADDR_STATUS  = 8'h31;
    localparam logic [7:0] ADDR_TESTOUT = 8'h33;
    localparam logic [7:0] ADDR_PADFN   = 8'h34;
    localparam logic [7:0] ADDR_ENGINE  = 8'h61;

    localparam int ARM_BIT = 1;
    localparam int OVR_BIT = 4;

    typedef enum logic [1:0] {
        PAD_UNKNOWN = 2'd0,
        PAD_LOW     = 2'd1,
        PAD_HIGH    = 2'd2,
        PAD_HIZ     = 2'd3
    } pad_code_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_PULLUP = 2'd1,
        SEQ_PULLDN = 2'd2
    } seq_state_e;

    function automatic pad_code_e classify(input logic up_s, input logic dn_s);
        pad_code_e c;
        unique case ({up_s, dn_s})
            2'b00:   c = PAD_LOW;
            2'b11:   c = PAD_HIGH;
            2'b10:   c = PAD_HIZ;
            default: c = PAD_UNKNOWN;
        endcase
        return c;
    endfunction

    function automatic int settle_cycles(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/pad_pull_seq.sv
module pad_pull_seq
    import pad_selftest_pkg::*;
#(
    parameter int HALF = 600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NPADS-1:0] pad_in,
    output logic             pull_up,
    output logic             pull_dn,
    output logic             busy,
    output logic             done,
    output logic [NPADS-1:0] up_samp
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            up_samp <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    cnt <= '0;
                    if (start) state <= SEQ_PULLUP;
                end
                SEQ_PULLUP: begin
                    if (cnt == LAST) begin
                        up_samp <= pad_in;
                        cnt     <= '0;
                        state   <= SEQ_PULLDN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_PULLDN: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign pull_up = (state == SEQ_PULLUP);
    assign pull_dn = (state == SEQ_PULLDN);
    assign busy    = (state != SEQ_IDLE);
    assign done    = (state == SEQ_PULLDN) && (cnt == LAST);

    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pull_up && pull_dn)); // R4

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R2

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R3

endmodule

// File: rtl/pad_classify.sv
module pad_classify
    import pad_selftest_pkg::*;
#(
    parameter int N = NPADS
) (
    input  logic [N-1:0]   up_s,
    input  logic [N-1:0]   dn_s,
    output logic [2*N-1:0] codes
);
    for (genvar g = 0; g < N; g++) begin : g_pad
        pad_code_e c;
        assign c = classify(up_s[g], dn_s[g]);
        assign codes[2*g +: 2] = c;
    end
endmodule

// File: rtl/pad_out_override.sv
module pad_out_override
    import pad_selftest_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            enter_we,
    input  logic            enter_bit,
    input  logic            tout_we,
    input  logic [7:0]      tout_data,
    output logic            mode,
    output logic [7:0]      tout_q,
    output logic [NOUT-1:0] drive
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= 1'b0;
            tout_q <= '0;
        end else begin
            if (enter_we && enter_bit) mode <= 1'b1;
            if (tout_we) tout_q <= tout_data;
        end
    end

    assign drive = mode ? tout_q[NOUT-1:0] : '0;

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode |=> mode); // R9

endmodule

// File: rtl/pad_selftest_ctrl.sv
module pad_selftest_ctrl
    import pad_selftest_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SETTLE_US = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_we,
    output logic [7:0]  reg_rdata,
    input  logic [3:0]  pad_in,
    output logic        pull_up_en,
    output logic        pull_dn_en,
    output logic        busy,
    output logic        ovr_en,
    output logic [3:0]  ovr_drive,
    output logic        serial_dis
);
    localparam int SETTLE = settle_cycles(CLK_HZ, SETTLE_US);
    localparam int HALF   = (SETTLE / 2 < 1) ? 1 : SETTLE / 2;

    logic [7:0]         eng_q;
    logic [7:0]         padfn_q;
    logic [2*NPADS-1:0] status_q;
    logic [7:0]         tout_q;
    logic [NPADS-1:0]   up_samp;
    logic [2*NPADS-1:0] codes;
    logic               done;
    logic               start;

    assign start = reg_we && (reg_addr == ADDR_STATUS) && eng_q[ARM_BIT] && !busy;

    pad_pull_seq #(.HALF(HALF)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .pad_in  (pad_in),
        .pull_up (pull_up_en),
        .pull_dn (pull_dn_en),
        .busy    (busy),
        .done    (done),
        .up_samp (up_samp)
    );

    pad_classify #(.N(NPADS)) u_cls (
        .up_s  (up_samp),
        .dn_s  (pad_in),
        .codes (codes)
    );

    pad_out_override u_ovr (
        .clk       (clk),
        .rst       (rst),
        .enter_we  (reg_we && (reg_addr == ADDR_PADFN)),
        .enter_bit (reg_wdata[OVR_BIT]),
        .tout_we   (reg_we && (reg_addr == ADDR_TESTOUT)),
        .tout_data (reg_wdata),
        .mode      (ovr_en),
        .tout_q    (tout_q),
        .drive     (ovr_drive)
    );

    assign serial_dis = ovr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q    <= '0;
            padfn_q  <= '0;
            status_q <= '0;
        end else begin
            if (reg_we && reg_addr == ADDR_ENGINE) eng_q   <= reg_wdata;
            if (reg_we && reg_addr == ADDR_PADFN)  padfn_q <= reg_wdata;
            if (done) status_q <= codes;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS:  reg_rdata = status_q;
            ADDR_ENGINE:  reg_rdata = eng_q;
            ADDR_TESTOUT: reg_rdata = tout_q;
            ADDR_PADFN: begin
                reg_rdata = padfn_q;
                reg_rdata[OVR_BIT] = ovr_en;
            end
            default:      reg_rdata = 8'h00;
        endcase
    end

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q) |-> $past(done)); // R3

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R3

endmodule

// File: tb/pad_selftest_ctrl_test.sv
module pad_selftest_ctrl_test;

    localparam int SETTLE = 12;
    localparam int HALF   = SETTLE / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic [3:0] pad_in;
    logic       pull_up_en, pull_dn_en, busy, ovr_en, serial_dis;
    logic [3:0] ovr_drive;
    logic [7:0] beh = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    pad_selftest_ctrl #(.CLK_HZ(1_000_000), .SETTLE_US(SETTLE)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .busy(busy),
        .ovr_en(ovr_en), .ovr_drive(ovr_drive), .serial_dis(serial_dis)
    );

    // behaviour per pad: 0 stuck low, 1 stuck high, 2 follows pull, 3 opposes pull
    always_comb begin
        for (int p = 0; p < 4; p++) begin
            case (beh[2*p +: 2])
                2'd0: pad_in[p] = 1'b0;
                2'd1: pad_in[p] = 1'b1;
                2'd2: pad_in[p] = pull_up_en;
                default: pad_in[p] = pull_dn_en;
            endcase
        end
    end

    function automatic logic [7:0] expect_status(input logic [7:0] b);
        logic [7:0] s;
        for (int p = 0; p < 4; p++) s[2*p +: 2] = 2'((b[2*p +: 2] + 1) % 4);
        return s;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL R3: watchdog expired actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h31, v); chk("R1 status", v, 8'h00);
        rd(8'h61, v); chk("R1 engine", v, 8'h00);
        rd(8'h33, v); chk("R1 testout", v, 8'h00);
        rd(8'h34, v); chk("R1 padfn", v, 8'h00);
        chk("R1 outputs", {busy, ovr_en, serial_dis, pull_up_en, pull_dn_en, ovr_drive},
            8'h00);

        // R2 start ignored while arm bit clear
        wr(8'h61, 8'hFD);
        wr(8'h31, 8'h5A);
        chk("R2 busy unarmed", {7'd0, busy}, 8'h00);
        repeat (SETTLE + 2) @(negedge clk);
        rd(8'h31, v); chk("R2 status unarmed", v, 8'h00);

        wr(8'h61, 8'h02);
        rd(8'h61, v); chk("R10 engine readback", v, 8'h02);
        rd(8'h55, v); chk("R10 unmapped", v, 8'h00);

        // sweep all 256 combinations of pad behaviour
        prev = 8'h00;
        for (int c = 0; c < 256; c++) begin
            beh = 8'(c);
            wr(8'h31, 8'(c * 37));
            chk("R2 busy started", {7'd0, busy}, 8'h01);
            chk("R4 pull-up phase start", {6'd0, pull_up_en, pull_dn_en}, 8'h02);
            repeat (HALF - 1) @(negedge clk);
            chk("R4 pull-up phase end", {6'd0, pull_up_en, pull_dn_en}, 8'h02);
            @(negedge clk);
            chk("R4 pull-down phase", {6'd0, pull_up_en, pull_dn_en}, 8'h01);
            repeat (HALF - 1) @(negedge clk);
            rd(8'h31, v); chk("R3 status held", v, prev);
            chk("R3 busy held", {7'd0, busy}, 8'h01);
            @(negedge clk);
            rd(8'h31, v); chk("R5 R6 status code", v, expect_status(8'(c)));
            chk("R3 busy cleared", {7'd0, busy}, 8'h00);
            prev = expect_status(8'(c));
        end

        // R7 start while busy ignored
        beh = 8'b10_01_00_11;
        wr(8'h31, 8'h00);
        repeat (2) @(negedge clk);
        wr(8'h31, 8'hFF);
        repeat (HALF * 2 - 5) @(negedge clk);
        rd(8'h31, v); chk("R7 status held", v, prev);
        @(negedge clk);
        rd(8'h31, v); chk("R7 on time", v, expect_status(beh));
        chk("R7 busy cleared", {7'd0, busy}, 8'h00);
        @(negedge clk);
        chk("R7 no restart", {7'd0, busy}, 8'h00);

        // R8 output-test mode
        wr(8'h33, 8'h0F);
        chk("R8 before mode", {ovr_en, serial_dis, 2'd0, ovr_drive}, 8'h00);
        wr(8'h34, 8'h10);
        chk("R8 mode entered", {ovr_en, serial_dis, 2'd0, ovr_drive}, 8'hCF);
        wr(8'h33, 8'hA6);
        chk("R8 drive follows", {4'd0, ovr_drive}, 8'h06);
        rd(8'h33, v); chk("R10 testout readback", v, 8'hA6);

        // R9 sticky
        wr(8'h34, 8'h00);
        chk("R9 mode kept", {6'd0, ovr_en, serial_dis}, 8'h03);
        rd(8'h34, v); chk("R9 padfn readback", v, 8'h10);
        wr(8'h34, 8'h2F);
        rd(8'h34, v); chk("R10 padfn readback", v, 8'h3F);

        // R1 R9 reset clears mode
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears mode", {ovr_en, serial_dis, 2'd0, ovr_drive}, 8'h00);
        rd(8'h31, v); chk("R1 status after reset", v, 8'h00);

        finish_run();
    end

endmodule